// File: doc/BRIEF.md
# Virtual Carrier-Sense Timer and Channel-Busy Combiner

This block holds the virtual carrier-sense timer of a wireless MAC and merges it with the physical carrier-sense indications into one channel-busy flag. Upstream logic that has decoded a received frame presents a reservation duration, counted in microseconds, together with the sender's 48-bit address. The block extends its reservation count with that duration unless the frame's sender is the programmed filter address. The count then drains by one on every microsecond tick supplied by the clock domain's timebase.

The channel-busy output is the OR of the receive-PHY activity, the transmit-PHY activity, the non-zero reservation and an external busy line. Each of these can be suppressed on its own through bits of a control word. A further bit forces the output busy. The same control word can disable or clear the reservation and clear two sticky flags that record whether the receive or transmit PHY has been active.

Top module: `carrier_sense_top`

## Requirements
- R1: After reset the reservation count is 0, both sticky activity flags are 0, and with all inputs low `ccaBusy` is 0.
- R2: A load pulse (`navLoad`=1) is accepted when control bit 1 is 0, the sender address differs from `{matchHi, matchLo}` and `navDur` is strictly greater than the present count. The count equals `navDur` after the next clock edge, even if `usTick` is high in the same cycle.
- R3: A load whose `navSrcAddr` equals `{matchHi, matchLo}` leaves the count unchanged. A single differing bit, including bit 47, makes the address distinct.
- R4: A load whose duration is less than or equal to the present count leaves the count unchanged.
- R5: With no accepted load, each cycle with `usTick`=1 lowers a non-zero count by one. A count of zero stays at zero.
- R6: Control bit 2 makes the count 0 after the next edge, and it takes priority over a load and a tick in the same cycle.
- R7: While control bit 1 is 1, `navBusy` is 0 and loads are ignored. Otherwise `navBusy` is 1 exactly when the count is non-zero.
- R8: `ccaBusy` = bit8 OR (`rxPhyActive` AND NOT bit5) OR (`txPhyActive` AND NOT bit6) OR (`navBusy` AND NOT bit7) OR (`extCcaBusy` AND bit21). It is combinational from the inputs and the present count.
- R9: Control bit 8 drives `ccaBusy` to 1 whatever the sources and masks are.
- R10: While control bit 21 is 0, `extCcaBusy` has no effect on `ccaBusy`.
- R11: `rxSeen`/`txSeen` become 1 after an edge at which `rxPhyActive`/`txPhyActive` is 1, and they stay 1. Control bit 23 (receive) or bit 24 (transmit) clears the flag at the next edge, and the clear wins over a concurrent activity.
- R12: With the default `NAV_W`=12 the largest reservation is 4095 µs. It loads intact and drains to zero in 4095 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle microsecond strobe |
| rxPhyActive | input | 1 | Receive PHY is active |
| txPhyActive | input | 1 | Transmit PHY is active |
| extCcaBusy | input | 1 | External busy indication |
| navLoad | input | 1 | Reservation load request |
| navDur | input | NAV_W | Requested reservation, µs |
| navSrcAddr | input | ADDR_W | Sender address of the frame |
| matchLo | input | 32 | Filter address, low 32 bits |
| matchHi | input | ADDR_W-32 | Filter address, high bits |
| ctrl | input | 32 | Control word (bits 1,2,5,6,7,8,21,23,24 used) |
| ccaBusy | output | 1 | Combined channel-busy flag |
| navBusy | output | 1 | Reservation contributes busy |
| navCount | output | NAV_W | Remaining reservation, µs |
| rxSeen | output | 1 | Sticky receive-activity flag |
| txSeen | output | 1 | Sticky transmit-activity flag |

## Verification
The bench builds the block with its defaults, `NAV_W`=12 and `ADDR_W`=48. This lets it sweep every load-and-drain sequence for durations 1 to 63, with saturation at zero, and also run one full 4095-tick drain. The combiner is swept over all 1024 combinations of the four sources, the three masks, the force bit, the external enable and the reservation disable. Each expected busy value is computed as a Boolean sum. The 48-bit address makes the filter-miss case reachable in its top bit.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Control word bit positions (decoded by the control module)
  localparam int CtlNavDisable = 1;
  localparam int CtlNavClear   = 2;
  localparam int CtlIgnRx      = 5;
  localparam int CtlIgnTx      = 6;
  localparam int CtlIgnNav     = 7;
  localparam int CtlForceBusy  = 8;
  localparam int CtlExtEnable  = 21;
  localparam int CtlClrRxSeen  = 23;
  localparam int CtlClrTxSeen  = 24;

  localparam int NumSrc   = 4;   // rx, tx, nav, external
  localparam int NumPhy   = 2;   // rx, tx sticky flags
  localparam int MatchLoW = 32;

  typedef struct packed {
    logic              navClear;
    logic              navEnable;
    logic [NumPhy-1:0] seenClr;
  } dpStrobe_t;
endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
(
  input  logic [31:0] ctrl,
  input  logic        rxAct,
  input  logic        txAct,
  input  logic        extBusy,
  input  logic        navNonzero,
  output dpStrobe_t   strb,
  output logic        navBusy,
  output logic        ccaBusy
);
  logic [NumSrc-1:0] srcVec;
  logic [NumSrc-1:0] srcEn;
  logic              anySrc;

  always_comb begin
    strb.navClear   = ctrl[CtlNavClear];
    strb.navEnable  = ~ctrl[CtlNavDisable];
    strb.seenClr    = {ctrl[CtlClrTxSeen], ctrl[CtlClrRxSeen]};
  end

  assign navBusy = navNonzero & strb.navEnable;

  assign srcVec = {extBusy, navBusy, txAct, rxAct};
  assign srcEn  = {ctrl[CtlExtEnable], ~ctrl[CtlIgnNav], ~ctrl[CtlIgnTx], ~ctrl[CtlIgnRx]};

  always_comb begin
    anySrc = 1'b0;
    for (int i = 0; i < NumSrc; i++) begin
      anySrc = anySrc | (srcVec[i] & srcEn[i]);
    end
  end

  assign ccaBusy = ctrl[CtlForceBusy] | anySrc;
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
#(
  parameter int NAV_W  = 12,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              usTick,
  input  logic              navLoad,
  input  logic [NAV_W-1:0]  navDur,
  input  logic [ADDR_W-1:0] navSrcAddr,
  input  logic [ADDR_W-1:0] matchAddr,
  input  logic [NumPhy-1:0] phyAct,
  output logic [NAV_W-1:0]  navCount,
  output logic              navNonzero,
  output logic [NumPhy-1:0] seen
);
  logic navCnt_nz;
  logic addrHit;
  logic loadTake;
  logic [NAV_W-1:0] navCnt;

  assign addrHit   = (navSrcAddr == matchAddr);
  assign navCnt_nz = (navCnt != '0);
  assign loadTake  = navLoad & strb.navEnable & ~addrHit & (navDur > navCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      navCnt <= '0;
    end else if (strb.navClear) begin
      navCnt <= '0;
    end else if (loadTake) begin
      navCnt <= navDur;
    end else if (usTick && navCnt_nz) begin
      navCnt <= navCnt - 1'b1;
    end
  end

  assign navCount   = navCnt;
  assign navNonzero = navCnt_nz;

  for (genvar g = 0; g < NumPhy; g++) begin : gSeen
    logic flag;
    always_ff @(posedge clk) begin
      if (!rstN)               flag <= 1'b0;
      else if (strb.seenClr[g]) flag <= 1'b0;
      else if (phyAct[g])      flag <= 1'b1;
    end
    assign seen[g] = flag;
  end
endmodule

// File: rtl/carrier_sense_top.sv
module carrier_sense_top
  import cs_pkg::*;
#(
  parameter int NAV_W  = 12,
  parameter int ADDR_W = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usTick,
  input  logic                 rxPhyActive,
  input  logic                 txPhyActive,
  input  logic                 extCcaBusy,
  input  logic                 navLoad,
  input  logic [NAV_W-1:0]     navDur,
  input  logic [ADDR_W-1:0]    navSrcAddr,
  input  logic [31:0]          matchLo,
  input  logic [ADDR_W-33:0]   matchHi,
  input  logic [31:0]          ctrl,
  output logic                 ccaBusy,
  output logic                 navBusy,
  output logic [NAV_W-1:0]     navCount,
  output logic                 rxSeen,
  output logic                 txSeen
);
  localparam int HiW = ADDR_W - MatchLoW;

  dpStrobe_t         strb;
  logic              navNonzero;
  logic [NumPhy-1:0] seen;
  logic [ADDR_W-1:0] matchAddr;

  assign matchAddr = {matchHi[HiW-1:0], matchLo};

  cs_ctrl u_ctrl (
    .ctrl       (ctrl),
    .rxAct      (rxPhyActive),
    .txAct      (txPhyActive),
    .extBusy    (extCcaBusy),
    .navNonzero (navNonzero),
    .strb       (strb),
    .navBusy    (navBusy),
    .ccaBusy    (ccaBusy)
  );

  cs_datapath #(.NAV_W(NAV_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .usTick     (usTick),
    .navLoad    (navLoad),
    .navDur     (navDur),
    .navSrcAddr (navSrcAddr),
    .matchAddr  (matchAddr),
    .phyAct     ({txPhyActive, rxPhyActive}),
    .navCount   (navCount),
    .navNonzero (navNonzero),
    .seen       (seen)
  );

  assign rxSeen = seen[0];
  assign txSeen = seen[1];
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int NAV_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             usTick,
  input logic             rxPhyActive,
  input logic             txPhyActive,
  input logic             extCcaBusy,
  input logic             navLoad,
  input logic [31:0]      ctrl,
  input logic             ccaBusy,
  input logic             navBusy,
  input logic [NAV_W-1:0] navCount,
  input logic             rxSeen,
  input logic             txSeen
);
  a_r5_tick_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (navCount != '0 && usTick && !navLoad && !ctrl[2]) |=> navCount == NAV_W'($past(navCount) - 1'b1));

  a_r5_no_growth_without_load: assert property (@(posedge clk) disable iff (!rstN)
    (!navLoad) |=> navCount <= $past(navCount));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrl[2] |=> navCount == '0);

  a_r7_disable: assert property (@(posedge clk) disable iff (!rstN)
    ctrl[1] |-> !navBusy);

  a_r9_force: assert property (@(posedge clk) disable iff (!rstN)
    ctrl[8] |-> ccaBusy);

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rxPhyActive && !txPhyActive && !extCcaBusy && !navBusy && !ctrl[8]) |-> !ccaBusy);

  a_r11_rx_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxPhyActive && !ctrl[23]) |=> rxSeen);

  a_r11_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrl[24] |=> !txSeen);
endmodule

bind carrier_sense_top cs_checker #(.NAV_W(NAV_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .usTick      (usTick),
  .rxPhyActive (rxPhyActive),
  .txPhyActive (txPhyActive),
  .extCcaBusy  (extCcaBusy),
  .navLoad     (navLoad),
  .ctrl        (ctrl),
  .ccaBusy     (ccaBusy),
  .navBusy     (navBusy),
  .navCount    (navCount),
  .rxSeen      (rxSeen),
  .txSeen      (txSeen)
);

// File: tb/sim_carrier_sense_top.sv
`timescale 1ns/1ps
module sim_carrier_sense_top;
  localparam int NAV_W  = 12;
  localparam int ADDR_W = 48;
  localparam logic [47:0] MATCH = 48'h4a21_0455d840;
  localparam logic [47:0] OTHER = 48'h5a21_0455d840;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 0, rxPhyActive = 0, txPhyActive = 0, extCcaBusy = 0, navLoad = 0;
  logic [NAV_W-1:0]  navDur = '0;
  logic [ADDR_W-1:0] navSrcAddr = '0;
  logic [31:0] matchLo = '0;
  logic [15:0] matchHi = '0;
  logic [31:0] ctrl = '0;
  logic ccaBusy, navBusy, rxSeen, txSeen;
  logic [NAV_W-1:0] navCount;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  carrier_sense_top #(.NAV_W(NAV_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .rxPhyActive(rxPhyActive),
    .txPhyActive(txPhyActive), .extCcaBusy(extCcaBusy), .navLoad(navLoad),
    .navDur(navDur), .navSrcAddr(navSrcAddr), .matchLo(matchLo), .matchHi(matchHi),
    .ctrl(ctrl), .ccaBusy(ccaBusy), .navBusy(navBusy), .navCount(navCount),
    .rxSeen(rxSeen), .txSeen(txSeen)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic loadNav(input int dur, input logic [47:0] addr, input bit tick);
    navLoad = 1; navDur = NAV_W'(dur); navSrcAddr = addr; usTick = tick;
    step();
    navLoad = 0; usTick = 0;
  endtask

  task automatic clearNav();
    ctrl = 32'h4;
    step();
    ctrl = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 navCount", navCount, 0);
    chk("R1 rxSeen", rxSeen, 0);
    chk("R1 txSeen", txSeen, 0);
    chk("R1 ccaBusy", ccaBusy, 0);
    matchLo = MATCH[31:0];
    matchHi = MATCH[47:32];

    // R5 load/drain sweep with saturation
    for (int d = 1; d < 64; d++) begin
      clearNav();
      loadNav(d, OTHER, 0);
      chk("R2 load", navCount, d);
      for (int k = 1; k <= d + 2; k++) begin
        usTick = 1; step(); usTick = 0;
        chk("R5 drain", navCount, (d - k) > 0 ? d - k : 0);
      end
    end

    // R2 load wins over tick
    clearNav();
    loadNav(5, OTHER, 0);
    loadNav(9, OTHER, 1);
    chk("R2 load beats tick", navCount, 9);
    // R4 equal and smaller loads ignored
    loadNav(9, OTHER, 0);
    chk("R4 equal load", navCount, 9);
    loadNav(3, OTHER, 0);
    chk("R4 smaller load", navCount, 9);
    // R3 address filter
    clearNav();
    loadNav(20, MATCH, 0);
    chk("R3 matched addr ignored", navCount, 0);
    loadNav(20, MATCH ^ 48'h8000_0000_0000, 0);
    chk("R3 bit47 differs", navCount, 20);
    // R6 clear priority
    ctrl = 32'h4; navLoad = 1; navDur = 30; navSrcAddr = OTHER; usTick = 1;
    step();
    ctrl = 0; navLoad = 0; usTick = 0;
    chk("R6 clear wins", navCount, 0);
    // R7 disable
    loadNav(20, OTHER, 0);
    ctrl = 32'h2; #1;
    chk("R7 navBusy off", navBusy, 0);
    chk("R7 cca idle", ccaBusy, 0);
    loadNav(40, OTHER, 0);
    chk("R7 load ignored", navCount, 20);
    ctrl = 0; #1;
    chk("R7 navBusy on", navBusy, 1);
    // R12 max duration
    clearNav();
    loadNav(4095, OTHER, 0);
    chk("R12 max load", navCount, 4095);
    usTick = 1;
    repeat (4095) step();
    usTick = 0;
    chk("R12 drained", navCount, 0);

    // R8/R9/R10 combiner sweep
    for (int v = 0; v < 1024; v++) begin
      bit rx, tx, ex, nv, igR, igT, igN, frc, exEn, dis;
      int exp;
      {dis, exEn, frc, igN, igT, igR, nv, ex, tx, rx} = v[9:0];
      clearNav();
      if (nv) loadNav(7, OTHER, 0);
      ctrl = 0;
      ctrl[1] = dis; ctrl[5] = igR; ctrl[6] = igT; ctrl[7] = igN;
      ctrl[8] = frc; ctrl[21] = exEn;
      rxPhyActive = rx; txPhyActive = tx; extCcaBusy = ex;
      #1;
      exp = int'(frc | (rx & !igR) | (tx & !igT) | (nv & !dis & !igN) | (ex & exEn));
      if (frc) chk("R9 force", ccaBusy, exp);
      else if (!exEn && ex) chk("R10 ext ignored", ccaBusy, exp);
      else chk("R8 combine", ccaBusy, exp);
      chk("R7 navBusy", navBusy, int'(nv & !dis));
      rxPhyActive = 0; txPhyActive = 0; extCcaBusy = 0; ctrl = 0;
    end

    // R11 sticky flags
    ctrl = 32'h0180_0000; step(); ctrl = 0;
    rxPhyActive = 1; step(); rxPhyActive = 0;
    step(); step();
    chk("R11 rx sticky", rxSeen, 1);
    chk("R11 tx untouched", txSeen, 0);
    rxPhyActive = 1; ctrl = 32'h0080_0000; step();
    rxPhyActive = 0; ctrl = 0;
    chk("R11 rx clear wins", rxSeen, 0);
    txPhyActive = 1; step(); txPhyActive = 0; step();
    chk("R11 tx sticky", txSeen, 1);
    ctrl = 32'h0100_0000; step(); ctrl = 0;
    chk("R11 tx clear", txSeen, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule